// File: doc/BRIEF.md
# Configurable Registered Fan-Out Buffer

This block is a clocked register bank whose output map is fixed by two static strap inputs. In the wide configuration it captures a 25-bit input word and presents it bit for bit on the low 25 positions of a 28-bit output bus. In the split configuration it captures a 14-bit field and drives every captured bit onto two output positions, so one register can feed twice as many loads. A second strap decides which 14-bit field of the input bus is captured in the split configuration: the low field or the high field.

Two active-low chip-select inputs gate the register load. When both are high the register keeps its value and the outputs do not toggle, which saves switching power on the loads. An active-low reset, asynchronous to the clock, clears the register and forces the whole output bus low.

Top module: `fanbuf_top`

## Requirements
- R1: With `cfgSplit` low, a rising clock edge that sees at least one chip-select low loads `dIn[24:0]` onto `qOut[24:0]`. `cfgUpper` has no effect in this configuration.
- R2: With `cfgSplit` low, `qOut[27:25]` stays low at all times.
- R3: With `cfgSplit` high and `cfgUpper` low, a loading edge captures `dIn[13:0]` and drives it onto both `qOut[13:0]` and `qOut[27:14]`.
- R4: With `cfgSplit` high and `cfgUpper` high, a loading edge captures `dIn[24:11]` and drives it onto both `qOut[13:0]` and `qOut[27:14]`.
- R5: With `cfgSplit` high, `qOut[13:0]` and `qOut[27:14]` are equal in every cycle.
- R6: When `csN` is 2'b11 at a rising edge, `qOut` keeps its previous value. `csN` values 2'b00, 2'b01 and 2'b10 all allow a load.
- R7: Driving `rstN` low sets `qOut` to all zeros at once, without waiting for a clock edge.
- R8: After `rstN` is released, `qOut` stays all zeros until the first rising edge that sees a chip-select low.
- R9: In the split configuration, input bits outside the selected 14-bit field have no effect on `qOut`.
- R10: `qOut` changes only at a rising clock edge (or at reset). Input changes between edges are not visible on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgSplit | input | 1 | Static strap: 0 = 25-bit one-to-one, 1 = 14-bit duplicated |
| cfgUpper | input | 1 | Static strap: selects the high input field in the duplicated configuration |
| csN | input | 2 | Chip selects, active low; a load happens if either is low |
| dIn | input | 25 | Data inputs |
| qOut | output | 28 | Registered outputs |

## Verification
On every clock cycle the assertions check that the two copies match in the split configuration, that the spare positions stay low in the wide configuration, that the register holds when both chip selects are high, that a loading edge places the selected field or word on the outputs, that reset forces zeros, and that the straps do not move outside reset. Only the bench scenarios can show the asynchronous nature of reset in the middle of a cycle, the zero outputs between reset release and the first loading edge, that input changes between edges stay invisible, and that bits outside the selected field never leak into the outputs.

// File: rtl/fanbuf_pkg.sv
package fanbuf_pkg;

  // Strobes passed from the control decode to the register datapath.
  typedef struct packed {
    logic load;      // register captures new data at this edge
    logic wideMode;  // one-to-one map active
    logic upperMap;  // duplicated map takes the high input field
  } fanbuf_strobe_t;

endpackage

// File: rtl/fanbuf_ctrl.sv
module fanbuf_ctrl
  import fanbuf_pkg::*;
#(
  parameter int CS_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgSplit,
  input  logic             cfgUpper,
  input  logic [CS_W-1:0]  csN,
  output fanbuf_strobe_t   strb
);

  logic anySelected;

  // Active-low selects: one low select is enough to enable a load.
  assign anySelected = ~(&csN);

  always_comb begin
    strb          = '0;
    strb.load     = anySelected;
    strb.wideMode = ~cfgSplit;
    strb.upperMap = cfgSplit & cfgUpper;
  end

  // Straps are static: they may only move while reset is held.
  assert_straps_static_R1 : assert property (
    @(posedge clk) disable iff (!rstN)
      $stable(cfgSplit) && $stable(cfgUpper)
  ) else $error("strap changed outside reset");

endmodule

// File: rtl/fanbuf_datapath.sv
module fanbuf_datapath
  import fanbuf_pkg::*;
#(
  parameter int WIDE_W   = 25,
  parameter int NARROW_W = 14
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  fanbuf_strobe_t          strb,
  input  logic [WIDE_W-1:0]       dIn,
  output logic [2*NARROW_W-1:0]   qOut
);

  localparam int OUT_W      = 2 * NARROW_W;
  localparam int UPPER_BASE = WIDE_W - NARROW_W;

  logic [OUT_W-1:0] nextBits;
  logic [OUT_W-1:0] liveMask;
  logic [OUT_W-1:0] qReg;

  // Per output position: pick the wide source or the duplicated source.
  for (genvar j = 0; j < OUT_W; j++) begin : gBit
    localparam int K = (j < NARROW_W) ? j : j - NARROW_W;
    logic narrowSrc;
    assign narrowSrc = strb.upperMap ? dIn[K + UPPER_BASE] : dIn[K];
    if (j < WIDE_W) begin : gShared
      assign nextBits[j] = strb.wideMode ? dIn[j] : narrowSrc;
      assign liveMask[j] = 1'b1;
    end else begin : gSpare
      assign nextBits[j] = strb.wideMode ? 1'b0 : narrowSrc;
      assign liveMask[j] = ~strb.wideMode;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qReg <= '0;
    end else if (strb.load) begin
      qReg <= nextBits;
    end
  end

  // Spare positions are masked so they stay low in the wide map.
  assign qOut = qReg & liveMask;

  // R6: without a load the register keeps its content.
  assert_hold_when_deselected_R6 : assert property (
    @(posedge clk) disable iff (!rstN)
      !strb.load |=> $stable(qReg)
  ) else $error("register changed while deselected");

endmodule

// File: rtl/fanbuf_top.sv
module fanbuf_top
  import fanbuf_pkg::*;
#(
  parameter int WIDE_W   = 25,
  parameter int NARROW_W = 14,
  parameter int CS_W     = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgSplit,
  input  logic                  cfgUpper,
  input  logic [CS_W-1:0]       csN,
  input  logic [WIDE_W-1:0]     dIn,
  output logic [2*NARROW_W-1:0] qOut
);

  localparam int OUT_W      = 2 * NARROW_W;
  localparam int UPPER_BASE = WIDE_W - NARROW_W;

  fanbuf_strobe_t strb;

  fanbuf_ctrl #(.CS_W(CS_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgSplit (cfgSplit),
    .cfgUpper (cfgUpper),
    .csN      (csN),
    .strb     (strb)
  );

  fanbuf_datapath #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) uPath (
    .clk  (clk),
    .rstN (rstN),
    .strb (strb),
    .dIn  (dIn),
    .qOut (qOut)
  );

  // R1: wide load lands on the low positions one edge later.
  assert_wide_load_R1 : assert property (
    @(posedge clk) disable iff (!rstN)
      (!cfgSplit && !(&csN)) |=> qOut[WIDE_W-1:0] == $past(dIn)
  ) else $error("wide load mismatch");

  // R2: spare positions low in the wide map.
  assert_spare_low_R2 : assert property (
    @(posedge clk) disable iff (!rstN)
      !cfgSplit |-> qOut[OUT_W-1:WIDE_W] == '0
  ) else $error("spare output not low");

  // R3: low field captured in the split map.
  assert_lower_field_R3 : assert property (
    @(posedge clk) disable iff (!rstN)
      (cfgSplit && !cfgUpper && !(&csN)) |=>
        qOut[NARROW_W-1:0] == $past(dIn[NARROW_W-1:0])
  ) else $error("low field load mismatch");

  // R4: high field captured in the split map.
  assert_upper_field_R4 : assert property (
    @(posedge clk) disable iff (!rstN)
      (cfgSplit && cfgUpper && !(&csN)) |=>
        qOut[NARROW_W-1:0] == $past(dIn[WIDE_W-1:UPPER_BASE])
  ) else $error("high field load mismatch");

  // R5: both copies identical.
  assert_copies_equal_R5 : assert property (
    @(posedge clk) disable iff (!rstN)
      cfgSplit |-> qOut[NARROW_W-1:0] == qOut[OUT_W-1:NARROW_W]
  ) else $error("duplicated copies differ");

  // R7: outputs low while reset is held.
  assert_reset_clears_R7 : assert property (
    @(posedge clk) !rstN |-> qOut == '0
  ) else $error("outputs not cleared in reset");

endmodule

// File: tb/fanbuf_top_test.sv
module fanbuf_top_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgSplit;
  logic        cfgUpper;
  logic [1:0]  csN;
  logic [24:0] dIn;
  logic [27:0] qOut;

  int checks = 0;
  int fails  = 0;
  logic [27:0] expQ;
  bit done = 0;

  always #2 clk = ~clk;

  fanbuf_top uut (
    .clk(clk), .rstN(rstN), .cfgSplit(cfgSplit), .cfgUpper(cfgUpper),
    .csN(csN), .dIn(dIn), .qOut(qOut)
  );

  function automatic logic [27:0] mapBits(logic [24:0] d, logic split, logic upper);
    logic [13:0] f;
    if (!split) return {3'b000, d};
    f = upper ? d[24:11] : d[13:0];
    return {f, f};
  endfunction

  task automatic check(bit ok, string req, logic [27:0] act, logic [27:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic runMode(logic split, logic upper, int n);
    string tag;
    tag = !split ? "R1" : (upper ? "R4 R9" : "R3 R9");
    @(negedge clk);
    rstN = 1'b0;
    cfgSplit = split;
    cfgUpper = upper;
    csN = 2'b11;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    expQ = '0;
    #1 check(qOut == 28'h0, "R8", qOut, 28'h0);
    // Deselected edge after release keeps zeros.
    @(negedge clk);
    dIn = 25'($urandom());
    @(posedge clk);
    #1 check(qOut == 28'h0, "R8 R6", qOut, 28'h0);
    // Directed: only ignored bits set in the split map.
    if (split) begin
      @(negedge clk);
      dIn = upper ? 25'h00007FF : 25'h1FFC000;
      csN = 2'b00;
      @(posedge clk);
      expQ = '0;
      #1 check(qOut == expQ, "R9", qOut, expQ);
    end
    for (int i = 0; i < n; i++) begin
      logic ld;
      @(negedge clk);
      dIn = 25'($urandom());
      csN = 2'($urandom());
      if (i < 3) csN = 2'(i);
      #1 check(qOut == expQ, "R10", qOut, expQ);
      ld = (csN != 2'b11);
      @(posedge clk);
      if (ld) expQ = mapBits(dIn, split, upper);
      #1 check(qOut == expQ, ld ? tag : "R6", qOut, expQ);
      if (split)
        check(qOut[13:0] == qOut[27:14], "R5", qOut, {qOut[13:0], qOut[13:0]});
      else
        check(qOut[27:25] == 3'b000, "R2", qOut, {3'b000, qOut[24:0]});
    end
    // Mid-cycle asynchronous reset.
    @(negedge clk);
    rstN = 1'b0;
    #1 check(qOut == 28'h0, "R7", qOut, 28'h0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; cfgSplit = 1'b0; cfgUpper = 1'b0; csN = 2'b11; dIn = '0;
    #3 check(qOut == 28'h0, "R7", qOut, 28'h0);
    runMode(1'b0, 1'b0, 300);
    runMode(1'b0, 1'b1, 200);
    runMode(1'b1, 1'b0, 300);
    runMode(1'b1, 1'b1, 300);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule